// File: doc/BRIEF.md
# Quad-Channel Parallel Converter Bus Sequencer

This block is a host-side controller for a parallel bus that feeds a quad-channel, 12-bit converter register file. Each channel in that target has two stages of level-sensitive storage. An input stage opens while a chip-select strobe is low and the channel address matches. An output stage opens for all channels together while a shared load strobe is low. The sequencer takes one command at a time on a synchronous valid/ready port and turns it into correctly ordered pin activity. Every setup, strobe, hold and pulse interval is a parameter counted in clock cycles.

Five operations are supported: write one channel, read one channel back, pulse the load strobe, pulse the target reset, and write every channel with its own value and then issue one load pulse. Because of that last operation, all channel outputs change together. A mode input keeps the load strobe low all the time, so every input write passes straight to the output. A one-cycle done pulse ends each command, and read data is presented alongside it.

Top module: `dac_bus_seq`

## Requirements
- R1: While `rst_n` is low and after its release, the bus is idle: `bus_cs_n`=1, `bus_ldac_n`=1, `bus_rst_n`=1, `bus_doe`=0, `rsp_done`=0, and `cmd_ready`=1.
- R2: Write (`cmd_op`=0). Address, `bus_rw`=0 and data are driven and stable for at least `T_AS` cycles before `bus_cs_n` falls. They stay unchanged while it is low, and it is low for exactly `T_CSW` cycles. A plain write does not change the target's channel outputs unless a load follows.
- R3: After `bus_cs_n` rises on a write, address, `bus_rw`, data and `bus_doe` remain unchanged for at least `T_AH` cycles.
- R4: Read (`cmd_op`=1). `bus_rw`=1 and the address are stable for at least `T_AS` cycles before `bus_cs_n` falls and stay so for at least `T_RHZ` cycles after it rises. `bus_doe` is never 1 while `bus_rw` is 1.
- R5: On a read, `bus_cs_n` is low for exactly `T_RACC` cycles. `rsp_data` holds `bus_din` as sampled at the clock edge `T_RACC` cycles after the strobe fell.
- R6: Load (`cmd_op`=2). `bus_ldac_n` is low for exactly `T_LDW` cycles, with no chip-select activity. Afterwards, every channel output equals its input stage.
- R7: Target reset (`cmd_op`=3). `bus_rst_n` is low for exactly `T_RSTW` cycles while `bus_cs_n` stays high. Afterwards, every channel's input and output stages hold the target's reset code.
- R8: Write-all (`cmd_op`=4). Channels are written in ascending order 0 to NCH-1, and channel i receives `cmd_bulk[i*DW +: DW]`. One load pulse follows, and all channel outputs change in the same clock cycle.
- R9: While `mode_transparent` is 1, `bus_ldac_n` is low from the next cycle on, so a write reaches the channel output without a load command. When the mode is 0, `bus_ldac_n` is high except during load pulses.
- R10: `cmd_ready` is 1 only when no command is in flight. A command is taken when `cmd_valid` and `cmd_ready` are both 1. Each command produces exactly one `rsp_done` pulse of one cycle, and `cmd_ready` is 1 in that same cycle.
- R11: Unused `cmd_op` codes (5 to 7) cause no bus activity and finish with `rsp_done` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command accepted this cycle if valid |
| cmd_op | input | 3 | 0 write, 1 read, 2 load, 3 target reset, 4 write-all |
| cmd_chan | input | AW | Channel for write and read |
| cmd_value | input | DW | Code for a single write |
| cmd_bulk | input | NCH*DW | Codes for write-all, channel i in bits i*DW +: DW |
| mode_transparent | input | 1 | Keep the load strobe low permanently |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DW | Last readback value |
| bus_addr | output | AW | Channel address on the bus |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_cs_n | output | 1 | Active-low chip-select strobe |
| bus_dout | output | DW | Write data toward the target |
| bus_doe | output | 1 | Write data is being driven |
| bus_din | input | DW | Read data from the target |
| bus_ldac_n | output | 1 | Active-low shared load strobe |
| bus_rst_n | output | 1 | Active-low target reset strobe |

## Verification
The events that must coincide are the output updates of all four channels. A write-all sets each input stage separately over several strobes, but the outputs must all move in the single cycle when the load strobe opens them. The bench makes every new code differ from the code currently at that channel's output. It then counts clock cycles in which any output changed and cycles in which every output changed, and expects exactly one of each per write-all. A bench model of the level-sensitive target sits on the pins, where a monitor measures setup, strobe width and hold in cycles against the parameters.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [2:0] {
        OP_WRITE = 3'd0,
        OP_READ  = 3'd1,
        OP_LOAD  = 3'd2,
        OP_RESET = 3'd3,
        OP_WRALL = 3'd4
    } dbs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_LOADP,
        ST_RSTP
    } dbs_st_e;

    function automatic int unsigned dbs_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dbs_timer.sv
module dbs_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
    import dbs_pkg::*;
#(
    parameter int unsigned DW     = 12,
    parameter int unsigned NCH    = 4,
    parameter int unsigned AW     = 2,
    parameter int unsigned TW     = 3,
    parameter int unsigned T_AS   = 2,
    parameter int unsigned T_CSW  = 3,
    parameter int unsigned T_AH   = 2,
    parameter int unsigned T_RACC = 4,
    parameter int unsigned T_RHZ  = 3,
    parameter int unsigned T_LDW  = 3,
    parameter int unsigned T_RSTW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_chan,
    input  logic [DW-1:0]     cmd_value,
    input  logic [NCH*DW-1:0] cmd_bulk,
    input  logic              mode_transparent,
    output logic              rsp_done,
    output logic [DW-1:0]     rsp_data,
    input  logic              tmr_last,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rw,
    output logic              bus_cs_n,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_doe,
    input  logic [DW-1:0]     bus_din,
    output logic              bus_ldac_n,
    output logic              bus_rst_n
);

    typedef struct packed {
        dbs_st_e            st;
        dbs_op_e            op;
        logic [AW-1:0]      ch;
        logic [DW-1:0]      value;
        logic [NCH*DW-1:0]  bulk;
        logic [DW-1:0]      rdata;
        logic               done;
        logic [AW-1:0]      addr;
        logic               rw;
        logic               cs_n;
        logic [DW-1:0]      dout;
        logic               doe;
        logic               ldac_n;
        logic               trst_n;
    } ctl_s;

    ctl_s s_d, s_q;

    function automatic logic [TW-1:0] dur_of(dbs_st_e st, logic rd);
        int unsigned v;
        case (st)
            ST_SETUP:  v = T_AS;
            ST_STROBE: v = rd ? T_RACC : T_CSW;
            ST_HOLD:   v = rd ? T_RHZ : T_AH;
            ST_LOADP:  v = T_LDW;
            ST_RSTP:   v = T_RSTW;
            default:   v = 1;
        endcase
        return TW'(v - 1);
    endfunction

    logic is_rd;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.op    = dbs_op_e'(cmd_op);
                    s_d.ch    = (cmd_op == OP_WRALL) ? '0 : cmd_chan;
                    s_d.value = cmd_value;
                    s_d.bulk  = cmd_bulk;
                    case (cmd_op)
                        OP_WRITE, OP_READ, OP_WRALL: s_d.st = ST_SETUP;
                        OP_LOAD:                     s_d.st = ST_LOADP;
                        OP_RESET:                    s_d.st = ST_RSTP;
                        default:                     s_d.done = 1'b1;
                    endcase
                end
            end
            ST_SETUP: begin
                if (tmr_last) s_d.st = ST_STROBE;
            end
            ST_STROBE: begin
                if (tmr_last) begin
                    if (s_q.op == OP_READ) s_d.rdata = bus_din;
                    s_d.st = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_last) begin
                    if (s_q.op == OP_WRALL) begin
                        if (s_q.ch == AW'(NCH - 1)) begin
                            s_d.st = ST_LOADP;
                        end else begin
                            s_d.ch = s_q.ch + 1'b1;
                            s_d.st = ST_SETUP;
                        end
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end
                end
            end
            ST_LOADP, ST_RSTP: begin
                if (tmr_last) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        // pin values for the state about to be entered
        is_rd = (s_d.op == OP_READ);
        case (s_d.st)
            ST_SETUP, ST_STROBE, ST_HOLD: begin
                s_d.addr = s_d.ch;
                s_d.rw   = is_rd;
                s_d.doe  = !is_rd;
                s_d.cs_n = (s_d.st != ST_STROBE);
                if (!is_rd) begin
                    s_d.dout = (s_d.op == OP_WRALL) ? s_d.bulk[int'(s_d.ch)*DW +: DW] : s_d.value;
                end
            end
            default: begin
                s_d.rw   = 1'b1;
                s_d.doe  = 1'b0;
                s_d.cs_n = 1'b1;
            end
        endcase
        s_d.ldac_n = !((s_d.st == ST_LOADP) || mode_transparent);
        s_d.trst_n = (s_d.st != ST_RSTP);

        tmr_load = (s_d.st != s_q.st);
        tmr_val  = dur_of(s_d.st, is_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.rw     <= 1'b1;
            s_q.cs_n   <= 1'b1;
            s_q.ldac_n <= 1'b1;
            s_q.trst_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready  = (s_q.st == ST_IDLE);
    assign rsp_done   = s_q.done;
    assign rsp_data   = s_q.rdata;
    assign bus_addr   = s_q.addr;
    assign bus_rw     = s_q.rw;
    assign bus_cs_n   = s_q.cs_n;
    assign bus_dout   = s_q.dout;
    assign bus_doe    = s_q.doe;
    assign bus_ldac_n = s_q.ldac_n;
    assign bus_rst_n  = s_q.trst_n;

    // R2
    fall_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> $stable(bus_addr) && $stable(bus_rw) && (bus_rw || $stable(bus_dout)));
    // R2
    low_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr) && $stable(bus_rw) && $stable(bus_dout));
    // R3
    rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> $stable(bus_addr) && $stable(bus_rw) && $stable(bus_dout) && $stable(bus_doe));
    // R4
    rd_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rw |-> !bus_doe);
    // R7
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |-> bus_cs_n && !bus_doe);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R10
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> cmd_ready);

endmodule

// File: rtl/dac_bus_seq.sv
module dac_bus_seq
    import dbs_pkg::*;
#(
    parameter int unsigned DW     = 12,
    parameter int unsigned NCH    = 4,
    parameter int unsigned T_AS   = 2,
    parameter int unsigned T_CSW  = 3,
    parameter int unsigned T_AH   = 2,
    parameter int unsigned T_RACC = 4,
    parameter int unsigned T_RHZ  = 3,
    parameter int unsigned T_LDW  = 3,
    parameter int unsigned T_RSTW = 5,
    localparam int unsigned AW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_chan,
    input  logic [DW-1:0]     cmd_value,
    input  logic [NCH*DW-1:0] cmd_bulk,
    input  logic              mode_transparent,
    output logic              rsp_done,
    output logic [DW-1:0]     rsp_data,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rw,
    output logic              bus_cs_n,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_doe,
    input  logic [DW-1:0]     bus_din,
    output logic              bus_ldac_n,
    output logic              bus_rst_n
);

    localparam int unsigned TMAX = dbs_max(dbs_max(dbs_max(T_AS, T_CSW), dbs_max(T_AH, T_RACC)),
                                           dbs_max(dbs_max(T_RHZ, T_LDW), T_RSTW));
    localparam int unsigned TW   = $clog2(TMAX + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_last;

    dbs_timer #(.TW(TW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    dbs_ctrl #(
        .DW(DW), .NCH(NCH), .AW(AW), .TW(TW),
        .T_AS(T_AS), .T_CSW(T_CSW), .T_AH(T_AH), .T_RACC(T_RACC),
        .T_RHZ(T_RHZ), .T_LDW(T_LDW), .T_RSTW(T_RSTW)
    ) i_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_valid        (cmd_valid),
        .cmd_ready        (cmd_ready),
        .cmd_op           (cmd_op),
        .cmd_chan         (cmd_chan),
        .cmd_value        (cmd_value),
        .cmd_bulk         (cmd_bulk),
        .mode_transparent (mode_transparent),
        .rsp_done         (rsp_done),
        .rsp_data         (rsp_data),
        .tmr_last         (tmr_last),
        .tmr_load         (tmr_load),
        .tmr_val          (tmr_val),
        .bus_addr         (bus_addr),
        .bus_rw           (bus_rw),
        .bus_cs_n         (bus_cs_n),
        .bus_dout         (bus_dout),
        .bus_doe          (bus_doe),
        .bus_din          (bus_din),
        .bus_ldac_n       (bus_ldac_n),
        .bus_rst_n        (bus_rst_n)
    );

endmodule

// File: tb/test_dac_bus_seq.sv
module test_dac_bus_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 12, NCH = 4, AW = 2;
    localparam int T_AS = 2, T_CSW = 3, T_AH = 2, T_RACC = 4, T_RHZ = 3, T_LDW = 3, T_RSTW = 5;
    localparam logic [DW-1:0] MID = 12'h800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_chan = '0;
    logic [DW-1:0] cmd_value = '0;
    logic [NCH*DW-1:0] cmd_bulk = '0;
    logic mode_transparent = 1'b0;
    logic rsp_done;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] bus_addr;
    logic bus_rw, bus_cs_n, bus_doe, bus_ldac_n, bus_rst_n;
    logic [DW-1:0] bus_dout, bus_din;

    dac_bus_seq #(
        .DW(DW), .NCH(NCH), .T_AS(T_AS), .T_CSW(T_CSW), .T_AH(T_AH),
        .T_RACC(T_RACC), .T_RHZ(T_RHZ), .T_LDW(T_LDW), .T_RSTW(T_RSTW)
    ) i_dac_bus_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_value(cmd_value), .cmd_bulk(cmd_bulk),
        .mode_transparent(mode_transparent), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_cs_n(bus_cs_n), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_ldac_n(bus_ldac_n), .bus_rst_n(bus_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- target model: two level-sensitive stages per channel
    logic [DW-1:0] in_r [NCH];
    logic [DW-1:0] dac_r [NCH];
    logic [DW-1:0] mdl_t;
    int rdcnt = 0;

    always @(negedge clk) begin
        if (!rst_n || !bus_rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                in_r[i]  <= MID;
                dac_r[i] <= MID;
            end
            rdcnt <= 0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                mdl_t = in_r[i];
                if (!bus_cs_n && !bus_rw && bus_addr == AW'(i)) mdl_t = bus_dout;
                in_r[i] <= mdl_t;
                if (!bus_ldac_n) dac_r[i] <= mdl_t;
            end
            rdcnt <= (!bus_cs_n && bus_rw) ? rdcnt + 1 : 0;
        end
    end

    assign bus_din = (rdcnt >= T_RACC) ? in_r[bus_addr] : ~in_r[bus_addr];

    // ---------------- pin timing monitor
    logic [AW+DW+1:0] prev_pins = '0;
    logic prev_cs = 1'b1, prev_ld = 1'b1, prev_rst = 1'b1;
    int stab = 0, lowcnt = 0, since_rise = 0, ldlow = 0, rstlow = 0, cs_falls = 0, ld_pulses = 0;
    bit hold_pend = 0, hold_rw = 0, lowchg = 0, ld_chk_en = 1;
    int wlog [16];
    int wlog_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic [AW+DW+1:0] pins;
            bit chg;
            int hreq;
            pins = {bus_addr, bus_rw, bus_dout, bus_doe};
            chg  = (pins != prev_pins);
            stab = chg ? 0 : stab + 1;
            hreq = hold_rw ? T_RHZ : T_AH;
            if (bus_rw && bus_doe) check(0, "R4 data driven during read", 1, 0);
            if (hold_pend) begin
                since_rise++;
                if (chg) begin
                    check(since_rise >= hreq, hold_rw ? "R4 read hold" : "R3 write hold", since_rise, hreq);
                    hold_pend = 0;
                end
            end
            if (prev_cs && !bus_cs_n) begin
                check(stab >= T_AS, bus_rw ? "R4 read setup" : "R2 write setup", stab, T_AS);
                if (hold_pend) begin
                    check(since_rise >= hreq, "R3 hold before next strobe", since_rise, hreq);
                    hold_pend = 0;
                end
                lowcnt = 1;
                lowchg = 0;
                cs_falls++;
                if (!bus_rw && wlog_n < 16) begin
                    wlog[wlog_n] = int'(bus_addr);
                    wlog_n++;
                end
            end else if (!bus_cs_n) begin
                lowcnt++;
                if (chg) lowchg = 1;
            end
            if (!prev_cs && bus_cs_n) begin
                if (bus_rw) check(lowcnt == T_RACC, "R5 read strobe width", lowcnt, T_RACC);
                else        check(lowcnt == T_CSW, "R2 write strobe width", lowcnt, T_CSW);
                check(!lowchg, "R2 pins stable while strobe low", lowchg, 0);
                hold_pend  = 1;
                since_rise = 0;
                hold_rw    = bus_rw;
            end
            if (!bus_ldac_n) ldlow++;
            else begin
                if (!prev_ld && ld_chk_en) begin
                    check(ldlow == T_LDW, "R6 load pulse width", ldlow, T_LDW);
                    ld_pulses++;
                end
                ldlow = 0;
            end
            if (!bus_rst_n) rstlow++;
            else begin
                if (!prev_rst) check(rstlow == T_RSTW, "R7 reset pulse width", rstlow, T_RSTW);
                rstlow = 0;
            end
            prev_pins = pins;
            prev_cs   = bus_cs_n;
            prev_ld   = bus_ldac_n;
            prev_rst  = bus_rst_n;
        end
    end

    // ---------------- simultaneity monitor on channel outputs
    logic [DW-1:0] dac_prev [NCH];
    int chg_cyc = 0, full_cyc = 0;
    initial for (int i = 0; i < NCH; i++) dac_prev[i] = MID;

    always @(posedge clk) begin
        int n;
        n = 0;
        for (int i = 0; i < NCH; i++) if (dac_r[i] !== dac_prev[i]) n++;
        if (n > 0) chg_cyc++;
        if (n == NCH) full_cyc++;
        for (int i = 0; i < NCH; i++) dac_prev[i] = dac_r[i];
    end

    // ---------------- expected state kept by the bench
    logic [DW-1:0] exp_in [NCH];
    logic [DW-1:0] exp_dac [NCH];

    task automatic run_cmd(input logic [2:0] op, input int ch, input logic [DW-1:0] val,
                           input logic [NCH*DW-1:0] bulk, output logic [DW-1:0] rd, output int lat);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_chan  = AW'(ch);
        cmd_value = val;
        cmd_bulk  = bulk;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        check(rsp_done, "R10 done pulse arrives", rsp_done, 1);
        check(cmd_ready, "R10 ready together with done", cmd_ready, 1);
        rd = rsp_data;
        @(negedge clk);
        check(!rsp_done, "R10 done lasts one cycle", rsp_done, 0);
    endtask

    task automatic do_write(input int ch, input logic [DW-1:0] v);
        logic [DW-1:0] rd;
        int lat;
        run_cmd(3'd0, ch, v, '0, rd, lat);
        exp_in[ch] = v;
        if (mode_transparent) exp_dac[ch] = v;
        check(dac_r[ch] == exp_dac[ch], "R2 output after write", dac_r[ch], exp_dac[ch]);
    endtask

    task automatic do_read(input int ch);
        logic [DW-1:0] rd;
        int lat;
        run_cmd(3'd1, ch, '0, '0, rd, lat);
        check(rd == exp_in[ch], "R5 readback value", rd, exp_in[ch]);
    endtask

    task automatic do_load();
        logic [DW-1:0] rd;
        int lat, f0;
        f0 = cs_falls;
        run_cmd(3'd2, 0, '0, '0, rd, lat);
        check(cs_falls == f0, "R6 no strobe during load", cs_falls - f0, 0);
        for (int i = 0; i < NCH; i++) begin
            exp_dac[i] = exp_in[i];
            check(dac_r[i] == exp_dac[i], "R6 output after load", dac_r[i], exp_dac[i]);
        end
    endtask

    task automatic do_treset();
        logic [DW-1:0] rd;
        int lat;
        run_cmd(3'd3, 0, '0, '0, rd, lat);
        for (int i = 0; i < NCH; i++) begin
            exp_in[i]  = MID;
            exp_dac[i] = MID;
            check(dac_r[i] == MID, "R7 output at reset code", dac_r[i], MID);
        end
    endtask

    task automatic print_summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(0, "watchdog expired", 0, 1);
        print_summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic [NCH*DW-1:0] bulk;
        int lat, c0, f0, l0, p0;
        void'($urandom(32'h1A2B3C));
        for (int i = 0; i < NCH; i++) begin
            exp_in[i]  = MID;
            exp_dac[i] = MID;
        end

        // R1 reset state
        repeat (3) @(negedge clk);
        check(bus_cs_n && bus_ldac_n && bus_rst_n && !bus_doe, "R1 idle pins in reset",
              {bus_cs_n, bus_ldac_n, bus_rst_n, bus_doe}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !rsp_done, "R1 ready and no done after reset", {cmd_ready, rsp_done}, 2'b10);
        check(bus_cs_n && bus_ldac_n && bus_rst_n && !bus_doe, "R1 idle pins after reset",
              {bus_cs_n, bus_ldac_n, bus_rst_n, bus_doe}, 4'b1110);

        // R7 target reset
        do_treset();

        // R2 write without load leaves output alone, R5 readback
        do_write(2, 12'h5A5);
        do_read(2);
        do_write(0, 12'h123);
        do_read(0);

        // R6 load
        do_load();

        // R8 write-all then one load: all outputs move in one cycle
        bulk = '0;
        for (int i = 0; i < NCH; i++) bulk[i*DW +: DW] = exp_dac[i] ^ DW'(12'h111 * (i + 1));
        c0 = chg_cyc;
        f0 = full_cyc;
        wlog_n = 0;
        p0 = ld_pulses;
        run_cmd(3'd4, 0, '0, bulk, rd, lat);
        for (int i = 0; i < NCH; i++) begin
            exp_in[i]  = bulk[i*DW +: DW];
            exp_dac[i] = exp_in[i];
            check(dac_r[i] == exp_dac[i], "R8 output after write-all", dac_r[i], exp_dac[i]);
            check(wlog[i] == i, "R8 ascending channel order", wlog[i], i);
        end
        check(wlog_n == NCH, "R8 one strobe per channel", wlog_n, NCH);
        check(ld_pulses - p0 == 1, "R8 single load pulse", ld_pulses - p0, 1);
        check(chg_cyc - c0 == 1, "R8 outputs change in one cycle", chg_cyc - c0, 1);
        check(full_cyc - f0 == 1, "R8 all channels change together", full_cyc - f0, 1);
        for (int i = 0; i < NCH; i++) do_read(i);

        // R11 unused opcodes
        for (int op = 5; op < 8; op++) begin
            f0 = cs_falls;
            l0 = ld_pulses;
            run_cmd(3'(op), 1, 12'hFFF, '1, rd, lat);
            check(lat == 1, "R11 unused opcode latency", lat, 1);
            check(cs_falls == f0 && ld_pulses == l0 && bus_rst_n, "R11 no bus activity",
                  cs_falls - f0, 0);
        end
        for (int i = 0; i < NCH; i++)
            check(dac_r[i] == exp_dac[i], "R11 outputs untouched", dac_r[i], exp_dac[i]);

        // R9 transparent mode
        ld_chk_en = 0;
        mode_transparent = 1'b1;
        repeat (2) @(negedge clk);
        check(!bus_ldac_n, "R9 load strobe held low", bus_ldac_n, 0);
        do_write(1, 12'hABC);
        check(dac_r[1] == 12'hABC, "R9 write reaches output directly", dac_r[1], 12'hABC);
        mode_transparent = 1'b0;
        repeat (2) @(negedge clk);
        check(bus_ldac_n, "R9 load strobe high again", bus_ldac_n, 1);
        ld_chk_en = 1;
        do_write(1, 12'h0F0);
        check(dac_r[1] == 12'hABC, "R9 output held without transparency", dac_r[1], 12'hABC);

        // R7 reset after activity
        do_treset();
        do_read(3);

        // random mix of write / read / load
        for (int k = 0; k < 80; k++) begin
            automatic int op = $urandom_range(0, 2);
            automatic int ch = $urandom_range(0, NCH - 1);
            automatic logic [DW-1:0] v = DW'($urandom);
            case (op)
                0: do_write(ch, v);
                1: do_read(ch);
                default: do_load();
            endcase
        end
        // corner codes
        do_write(3, 12'hFFF);
        do_write(2, 12'h000);
        do_load();
        do_read(3);
        do_read(2);

        repeat (4) @(negedge clk);
        print_summary();
        $finish;
    end

endmodule